// File: doc/BRIEF.md
# Serial DMA Register and Status Controller

This block is the CPU-facing register front end of a serial-port transfer engine. A processor uses a small register bus to load a 24-bit DRAM address. It then writes one of four command offsets to launch a transfer. The four transfers are a 64-byte copy into DRAM, a 64-byte copy out of DRAM, a single 4-byte IO write and a single 4-byte IO read. The block turns each accepted command into a one-cycle start pulse toward an abstract transfer engine. That pulse carries the direction, the size and the address. The block then waits for the engine's done pulse.

A status word at offset 0x18 reports whether the engine is busy, whether an IO read is waiting, whether an overlapping request was rejected, and whether an interrupt is pending. A command that overlaps an active transfer is dropped and latches a sticky error. The one exception is an IO read that arrives behind a write: it is parked and then issued as soon as that write finishes. Data returned by an IO read is held in a register that the CPU reads back at offset 0x14. The interrupt output is a level that stays high until the CPU writes the status offset.

Top module: `sdma_regs`

## Requirements
- R1: Offset 0x00 holds the DRAM address. Bits [23:0] are written from write data and read back, bits [31:24] read as 0, and the register resets to 0.
- R2: When idle, a write to 0x04 gives, one cycle later, a single-cycle eng_start_o with eng_dir_o=0 (toward DRAM) and eng_size_o=1 (64 bytes). A write to 0x10 gives the same with eng_dir_o=1 (toward the peripheral). In both cases eng_addr_o equals the DRAM address register.
- R3: When idle, a write to 0x08 starts an IO write: eng_dir_o=1, eng_size_o=0 (4 bytes), eng_wdata_o equals the written data, and eng_addr_o equals the DRAM address register. When idle, a write to 0x14 starts an IO read with eng_dir_o=0 and eng_size_o=0.
- R4: Status bit 0 reads 1 from the cycle after a read DMA, write DMA or IO write is accepted, until the cycle after its eng_done_i.
- R5: Status bit 1 reads 1 while an IO read or an IO write is in progress.
- R6: An IO read request made while a write DMA or an IO write is in progress, and not in the cycle of its done, sets status bit 2. It is then issued as an IO read start one cycle after that write's done, which also clears bit 2.
- R7: Status bit 3 is set, and the request dropped, in three cases: a command to 0x04, 0x08 or 0x10 while any transfer is active; an IO read while an IO read or read DMA is active; and an IO read while a read is already pending or in the cycle of a done. Only reset clears this bit.
- R8: A done that ends a DMA or an IO write sets status bit 12 and irq_o, both at level 1, until a write of any value to 0x18. If a set and that write fall in the same cycle, the set wins. Completing an IO read raises no interrupt.
- R9: eng_rdata_i is captured on the done of an IO read and is returned on reads of offset 0x14.
- R10: Status bits [11:4] and [31:13] read 0. Reads of unmapped offsets return 0, and reg_rdata_o is 0 when reg_rd_i is low.
- R11: eng_done_i while no transfer is active changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| eng_start_o | output | 1 | One-cycle transfer start |
| eng_dir_o | output | 1 | 0 toward DRAM, 1 toward peripheral |
| eng_size_o | output | 1 | 1 for 64 bytes, 0 for 4 bytes |
| eng_addr_o | output | 24 | DRAM address for the transfer |
| eng_wdata_o | output | 32 | IO write data |
| eng_done_i | input | 1 | One-cycle transfer completion |
| eng_rdata_i | input | 32 | IO read data from the engine |
| irq_o | output | 1 | Level interrupt |

## Verification
The engine is exercised with isolated transfers of each of the four kinds, which separates the direction and size encodings and shows which kinds raise the interrupt. Back-to-back requests are then issued against every kind of active transfer. These separate a dropped command with a sticky error from an IO read that is parked and later replayed. Collisions are also placed on the exact done cycle, and a status clear is placed in the same cycle as an interrupt set, to tell apart the priority choices. Stray done pulses and unmapped or unstrobed reads confirm that nothing moves when it should not.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_DMA_RD = 3'd1,
    K_DMA_WR = 3'd2,
    K_IO_WR  = 3'd3,
    K_IO_RD  = 3'd4
  } kind_e;

  localparam logic [7:0] OFF_ADDR   = 8'h00;
  localparam logic [7:0] OFF_DMA_RD = 8'h04;
  localparam logic [7:0] OFF_IO_WR  = 8'h08;
  localparam logic [7:0] OFF_DMA_WR = 8'h10;
  localparam logic [7:0] OFF_IO_RD  = 8'h14;
  localparam logic [7:0] OFF_STAT   = 8'h18;

  localparam int unsigned ST_DMA_BUSY = 0;
  localparam int unsigned ST_IO_BUSY  = 1;
  localparam int unsigned ST_PEND     = 2;
  localparam int unsigned ST_ERR      = 3;
  localparam int unsigned ST_IRQ      = 12;
endpackage

// File: rtl/sdma_decode.sv
module sdma_decode
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic              addr_wr_o,
  output logic              dma_rd_o,
  output logic              dma_wr_o,
  output logic              io_wr_o,
  output logic              io_rd_o,
  output logic              stat_wr_o
);
  always_comb begin
    addr_wr_o = wr_i && (addr_i == ADDR_W'(OFF_ADDR));
    dma_rd_o  = wr_i && (addr_i == ADDR_W'(OFF_DMA_RD));
    dma_wr_o  = wr_i && (addr_i == ADDR_W'(OFF_DMA_WR));
    io_wr_o   = wr_i && (addr_i == ADDR_W'(OFF_IO_WR));
    io_rd_o   = wr_i && (addr_i == ADDR_W'(OFF_IO_RD));
    stat_wr_o = wr_i && (addr_i == ADDR_W'(OFF_STAT));
  end
endmodule

// File: rtl/sdma_xfer_ctrl.sv
module sdma_xfer_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_rd_i,
  input  logic          dma_wr_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [AW-1:0] dram_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eng_done_i,
  input  logic [DW-1:0] eng_rdata_i,
  output logic          eng_start_o,
  output logic          eng_dir_o,
  output logic          eng_size_o,
  output logic [AW-1:0] eng_addr_o,
  output logic [DW-1:0] eng_wdata_o,
  output kind_e         kind_o,
  output logic          pend_o,
  output logic          err_o,
  output logic          irq_set_o,
  output logic [DW-1:0] hold_o
);
  kind_e         kind_q;
  logic          pend_q, err_q, start_q, dir_q, size_q;
  logic [AW-1:0] eaddr_q, paddr_q;
  logic [DW-1:0] ewdata_q, hold_q;

  logic busy, wr_kind, done_v, any_cmd;
  kind_e new_kind;

  always_comb begin
    busy    = (kind_q != K_IDLE);
    wr_kind = (kind_q == K_DMA_WR) || (kind_q == K_IO_WR);
    done_v  = eng_done_i && busy;
    any_cmd = dma_rd_i || dma_wr_i || io_wr_i || io_rd_i;
    new_kind = dma_rd_i ? K_DMA_RD :
               dma_wr_i ? K_DMA_WR :
               io_wr_i  ? K_IO_WR  : K_IO_RD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q   <= K_IDLE;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      size_q   <= 1'b0;
      eaddr_q  <= '0;
      paddr_q  <= '0;
      ewdata_q <= '0;
      hold_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (done_v) begin
        if (kind_q == K_IO_RD) hold_q <= eng_rdata_i;
        if (pend_q) begin
          // replay the parked IO read
          kind_q  <= K_IO_RD;
          start_q <= 1'b1;
          dir_q   <= 1'b0;
          size_q  <= 1'b0;
          eaddr_q <= paddr_q;
          pend_q  <= 1'b0;
        end else begin
          kind_q <= K_IDLE;
        end
      end
      if (any_cmd) begin
        if (!busy) begin
          kind_q  <= new_kind;
          start_q <= 1'b1;
          dir_q   <= (new_kind == K_DMA_WR) || (new_kind == K_IO_WR);
          size_q  <= (new_kind == K_DMA_RD) || (new_kind == K_DMA_WR);
          eaddr_q <= dram_addr_i;
          if (new_kind == K_IO_WR) ewdata_q <= wdata_i;
        end else if (io_rd_i && wr_kind && !pend_q && !done_v) begin
          pend_q  <= 1'b1;
          paddr_q <= dram_addr_i;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign eng_start_o = start_q;
  assign eng_dir_o   = dir_q;
  assign eng_size_o  = size_q;
  assign eng_addr_o  = eaddr_q;
  assign eng_wdata_o = ewdata_q;
  assign kind_o      = kind_q;
  assign pend_o      = pend_q;
  assign err_o       = err_q;
  assign irq_set_o   = done_v && (kind_q != K_IO_RD);
  assign hold_o      = hold_q;

  p_start_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (kind_q != K_IDLE));
  p_pend_behind_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (kind_q == K_DMA_WR || kind_q == K_IO_WR));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_idle_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && kind_q == K_IDLE && !any_cmd) |=> (kind_q == K_IDLE && !start_q));
endmodule

// File: rtl/sdma_regfile.sv
module sdma_regfile
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              addr_wr_i,
  input  logic              stat_wr_i,
  input  logic [AW-1:0]     wdata_i,
  input  logic              irq_set_i,
  input  kind_e             kind_i,
  input  logic              pend_i,
  input  logic              err_i,
  input  logic [DW-1:0]     hold_i,
  output logic [AW-1:0]     dram_addr_o,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [AW-1:0] dram_addr_q;
  logic          irq_q;
  logic [DW-1:0] stat_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dram_addr_q <= '0;
      irq_q       <= 1'b0;
    end else begin
      if (addr_wr_i) dram_addr_q <= wdata_i;
      if (irq_set_i)      irq_q <= 1'b1;  // set beats clear
      else if (stat_wr_i) irq_q <= 1'b0;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_DMA_BUSY] = (kind_i == K_DMA_RD) || (kind_i == K_DMA_WR) || (kind_i == K_IO_WR);
    stat_w[ST_IO_BUSY]  = (kind_i == K_IO_WR) || (kind_i == K_IO_RD);
    stat_w[ST_PEND]     = pend_i;
    stat_w[ST_ERR]      = err_i;
    stat_w[ST_IRQ]      = irq_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_W'(OFF_ADDR))       rdata_o = DW'(dram_addr_q);
      else if (addr_i == ADDR_W'(OFF_STAT))  rdata_o = stat_w;
      else if (addr_i == ADDR_W'(OFF_IO_RD)) rdata_o = hold_i;
    end
  end

  assign dram_addr_o = dram_addr_q;
  assign irq_o       = irq_q;

  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stat_wr_i) |=> irq_q);
  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !irq_set_i) |=> !irq_q);
  p_no_rd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              eng_start_o,
  output logic              eng_dir_o,
  output logic              eng_size_o,
  output logic [AW-1:0]     eng_addr_o,
  output logic [DW-1:0]     eng_wdata_o,
  input  logic              eng_done_i,
  input  logic [DW-1:0]     eng_rdata_i,
  output logic              irq_o
);
  logic addr_wr, dma_rd, dma_wr, io_wr, io_rd, stat_wr;
  logic pend, err, irq_set;
  kind_e kind;
  logic [AW-1:0] dram_addr;
  logic [DW-1:0] hold;

  sdma_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .addr_wr_o (addr_wr),
    .dma_rd_o  (dma_rd),
    .dma_wr_o  (dma_wr),
    .io_wr_o   (io_wr),
    .io_rd_o   (io_rd),
    .stat_wr_o (stat_wr)
  );

  sdma_xfer_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dma_rd_i    (dma_rd),
    .dma_wr_i    (dma_wr),
    .io_wr_i     (io_wr),
    .io_rd_i     (io_rd),
    .dram_addr_i (dram_addr),
    .wdata_i     (reg_wdata_i),
    .eng_done_i  (eng_done_i),
    .eng_rdata_i (eng_rdata_i),
    .eng_start_o (eng_start_o),
    .eng_dir_o   (eng_dir_o),
    .eng_size_o  (eng_size_o),
    .eng_addr_o  (eng_addr_o),
    .eng_wdata_o (eng_wdata_o),
    .kind_o      (kind),
    .pend_o      (pend),
    .err_o       (err),
    .irq_set_o   (irq_set),
    .hold_o      (hold)
  );

  sdma_regfile #(.ADDR_W(ADDR_W), .AW(AW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (reg_addr_i),
    .rd_i        (reg_rd_i),
    .addr_wr_i   (addr_wr),
    .stat_wr_i   (stat_wr),
    .wdata_i     (reg_wdata_i[AW-1:0]),
    .irq_set_i   (irq_set),
    .kind_i      (kind),
    .pend_i      (pend),
    .err_i       (err),
    .hold_i      (hold),
    .dram_addr_o (dram_addr),
    .rdata_o     (reg_rdata_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/sdma_regs_tb.sv
`timescale 1ns/1ps
module sdma_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, done = 1'b0;
  logic [31:0] wdata = '0, drd = '0;
  logic [31:0] rdata;
  logic        start, dir, size, irq;
  logic [23:0] eaddr;
  logic [31:0] ewdata;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdma_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eng_start_o(start), .eng_dir_o(dir),
    .eng_size_o(size), .eng_addr_o(eaddr), .eng_wdata_o(ewdata), .eng_done_i(done),
    .eng_rdata_i(drd), .irq_o(irq)
  );

  // reference model: 0 idle, 1 dma to DRAM, 2 dma to peripheral, 3 io write, 4 io read
  int          mk;
  bit          mp, merr, mirq, ms, mdir, msize;
  logic [23:0] maddr, mpaddr, meaddr;
  logic [31:0] mhold, mwd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk = 0; mp = 0; merr = 0; mirq = 0; ms = 0; mdir = 0; msize = 0;
      maddr = '0; mpaddr = '0; meaddr = '0; mhold = '0; mwd = '0;
    end else begin
      int  ok;
      bit  op, busy, wrk, dv, setirq;
      logic [23:0] oaddr;
      ok = mk; op = mp; oaddr = maddr;
      busy = (ok != 0); wrk = (ok == 2 || ok == 3); dv = done && busy;
      ms = 0; setirq = 0;
      if (dv) begin
        if (ok == 4) mhold = drd;
        else setirq = 1;
        if (op) begin
          mk = 4; ms = 1; mdir = 0; msize = 0; meaddr = mpaddr; mp = 0;
        end else mk = 0;
      end
      if (wr) begin
        case (addr)
          5'h00: maddr = wdata[23:0];
          5'h18: if (!setirq) mirq = 0;
          5'h04, 5'h10, 5'h08, 5'h14: begin
            int nk;
            nk = (addr == 5'h04) ? 1 : (addr == 5'h10) ? 2 : (addr == 5'h08) ? 3 : 4;
            if (!busy) begin
              mk = nk; ms = 1; mdir = (nk == 2 || nk == 3); msize = (nk <= 2); meaddr = oaddr;
              if (nk == 3) mwd = wdata;
            end else if (nk == 4 && wrk && !op && !dv) begin
              mp = 1; mpaddr = oaddr;
            end else merr = 1;
          end
          default: ;
        endcase
      end
      if (setirq) mirq = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string st;
      st = (mk == 3) ? "R3 io write start" : (mk == 4) ? "R6/R3 io read start" : "R2 dma start";
      chk(st, {31'b0, start}, {31'b0, ms});
      if (ms) begin
        chk({st, " dir"}, {31'b0, dir}, {31'b0, mdir});
        chk({st, " size"}, {31'b0, size}, {31'b0, msize});
        chk({st, " addr"}, {8'b0, eaddr}, {8'b0, meaddr});
        if (mk == 3) chk("R3 io wdata", ewdata, mwd);
      end
      chk("R8 irq_o", {31'b0, irq}, {31'b0, mirq});
      if (!rd) chk("R10 rdata without strobe", rdata, 32'h0);
      else begin
        case (addr)
          5'h00: chk("R1 dram address", rdata, {8'b0, maddr});
          5'h14: chk("R9 io read hold", rdata, mhold);
          5'h18: begin
            chk("R4 dma busy", {31'b0, rdata[0]}, {31'b0, (mk >= 1 && mk <= 3)});
            chk("R5 io busy", {31'b0, rdata[1]}, {31'b0, (mk == 3 || mk == 4)});
            chk("R6 pending", {31'b0, rdata[2]}, {31'b0, mp});
            chk("R7 error", {31'b0, rdata[3]}, {31'b0, merr});
            chk("R8 irq bit", {31'b0, rdata[12]}, {31'b0, mirq});
            chk("R10 unused status bits", rdata & 32'hFFFF_EFF0, 32'h0);
          end
          default: chk("R10 unmapped read", rdata, 32'h0);
        endcase
      end
    end
  end

  task automatic cyc(input logic [4:0] a, input logic w, input logic r,
                     input logic [31:0] d, input logic dn, input logic [31:0] dr);
    addr = a; wr = w; rd = r; wdata = d; done = dn; drd = dr;
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(5'h00, 0, 0, 32'h0, 0, 32'h0);
  endtask

  task automatic rdreg(input logic [4:0] a);
    cyc(a, 0, 1, 32'h0, 0, 32'h0);
  endtask

  task automatic wrreg(input logic [4:0] a, input logic [31:0] d);
    cyc(a, 1, 0, d, 0, 32'h0);
  endtask

  task automatic fin();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      fin();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // reset state
    rdreg(5'h18); rdreg(5'h00); rdreg(5'h14);
    // R1: upper bits masked
    wrreg(5'h00, 32'hFFFF_FFFF); rdreg(5'h00);
    wrreg(5'h00, 32'h0012_3454); rdreg(5'h00);
    // R2 dma to DRAM, R4 busy, R8 interrupt and clear
    wrreg(5'h04, 32'h0); idle(2); rdreg(5'h18);
    cyc(5'h00, 0, 0, 0, 1, 0); rdreg(5'h18); idle(1);
    wrreg(5'h18, 32'h0); rdreg(5'h18);
    // R2 dma to peripheral, R6 parked io read replayed, R9 data capture
    wrreg(5'h00, 32'h00AB_CDE0);
    wrreg(5'h10, 32'h0); wrreg(5'h14, 32'h0); rdreg(5'h18);
    cyc(5'h00, 0, 0, 0, 1, 32'h1111_1111); rdreg(5'h18); rdreg(5'h18);
    cyc(5'h00, 0, 0, 0, 1, 32'hCAFE_F00D); rdreg(5'h14); rdreg(5'h18);
    wrreg(5'h18, 32'h0);
    // R3 io write, R5 busy, R7 overlapping dma dropped
    wrreg(5'h08, 32'hDEAD_BEEF); rdreg(5'h18);
    wrreg(5'h04, 32'h0); rdreg(5'h18);
    cyc(5'h00, 0, 0, 0, 1, 0); rdreg(5'h18);
    // R7 sticky against status write
    wrreg(5'h18, 32'hFFFF_FFFF); rdreg(5'h18);
    // R11 done while idle
    cyc(5'h00, 0, 0, 0, 1, 32'h5555_AAAA); rdreg(5'h18); rdreg(5'h14);
    checks++;
    if (irq !== 1'b0 || start !== 1'b0) begin
      errors++;
      $display("FAIL R11 idle done act=%b%b exp=00", irq, start);
    end
    // R3 io read from idle, second read rejected, no interrupt on completion
    wrreg(5'h14, 32'h0); wrreg(5'h14, 32'h0); rdreg(5'h18);
    cyc(5'h00, 0, 0, 0, 1, 32'h0BAD_F00D); rdreg(5'h14); rdreg(5'h18);
    // R8 set wins over same-cycle clear
    wrreg(5'h10, 32'h0); idle(1);
    cyc(5'h18, 1, 0, 0, 1, 0); rdreg(5'h18);
    wrreg(5'h18, 32'h0); rdreg(5'h18);
    // R7 io read in the done cycle of a write is rejected; second pending rejected
    wrreg(5'h08, 32'h0000_0042);
    cyc(5'h14, 1, 0, 0, 1, 0); rdreg(5'h18);
    wrreg(5'h10, 32'h0); wrreg(5'h14, 32'h0); wrreg(5'h14, 32'h0); rdreg(5'h18);
    cyc(5'h00, 0, 0, 0, 1, 0); idle(1);
    cyc(5'h00, 0, 0, 0, 1, 32'h7777_0001); rdreg(5'h14);
    // R10 unmapped offsets and unstrobed reads
    rdreg(5'h0C); rdreg(5'h1C); idle(2);
    fin();
  end
endmodule